// File: doc/BRIEF.md
# SHA-3 Vector Logic Execute Unit

This block executes the three vector instructions that accelerate Keccak permutation rounds: a three-input XOR, a bit-clear-then-XOR, and an XOR followed by a rotate right. It accepts a 32-bit instruction word together with the contents of up to three 128-bit source registers. It decodes the word against two instruction classes. For each recognised operation it applies the function separately to two independent 64-bit lanes and returns the full 128-bit result with the destination register index.

One registered stage sits between a valid/ready input handshake and a valid/ready output handshake. A feature-enable input switches the whole extension on or off. When it is off, every word in either class completes as undefined. A word that belongs to neither class is passed back as not claimed, so that a neighbouring decoder can take it. Undefined and unclaimed words never request a register write.

Top module: `sha3_vec_unit`

## Requirements
- R1: A word with `(insn & 0xff808000) == 0xce000000` and field bits 22..21 equal to 0 produces, in each lane, src_n XOR src_m XOR src_a. The operands are src_n (index in bits 9..5), src_m (bits 20..16) and src_a (bits 14..10).
- R2: In the same class, bits 22..21 equal to 1 produce, in each lane, src_n XOR (src_m AND NOT src_a).
- R3: A word with `(insn & 0xffe00000) == 0xce800000` produces, in each lane, (src_n XOR src_m) rotated right by the unsigned amount in bits 15..10.
- R4: In that rotate class, an amount of 0 returns the XOR unchanged, and an amount of 63 rotates right by 63.
- R5: In the three-input class, bits 22..21 equal to 2 or 3 complete with `out_undef`=1, `out_wr`=0 and `out_result`=0.
- R6: While `feat_en` is 0, every word of either class completes with `out_undef`=1, `out_wr`=0 and `out_result`=0.
- R7: A word in neither class completes with `out_unclaimed`=1, `out_undef`=0, `out_wr`=0 and `out_result`=0.
- R8: Lane 0 is bits 63..0 and lane 1 is bits 127..64. The lanes are computed independently, and all 128 result bits are written (`out_wr`=1).
- R9: A word accepted on a rising edge (`in_valid` and `in_ready` high) appears with `out_valid`=1 after that edge. `out_dest` equals its bits 4..0.
- R10: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and all outputs hold their values. Every completed word raises exactly one of `out_wr`, `out_undef` and `out_unclaimed`.
- R11: After synchronous reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_en | input | 1 | Enables the SHA-3 instruction group |
| in_valid | input | 1 | Instruction and operands present |
| in_ready | output | 1 | Stage can accept a word |
| in_insn | input | 32 | Instruction word |
| in_src_n | input | 128 | Operand selected by bits 9..5 |
| in_src_m | input | 128 | Operand selected by bits 20..16 |
| in_src_a | input | 128 | Operand selected by bits 14..10 |
| out_valid | output | 1 | Result stage holds a completed word |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 128 | Two-lane result, zero when not written |
| out_dest | output | 5 | Destination register index |
| out_wr | output | 1 | Destination must be written |
| out_undef | output | 1 | Undefined instruction |
| out_unclaimed | output | 1 | Word not handled by this unit |

## Verification
A wrong decode shows at the ports in the first cycle after the word is accepted. The wrong one of the three status flags is raised, or lane data come out non-zero on an undefined word. A fault in one lane's logic shows only in that half of the result, so the tests use lane patterns that differ between the halves and rotate amounts at both ends of the range. A broken hold path shows as output data or flags changing during a stall, before the consumer has taken them.

// File: rtl/sha3_vec_pkg.sv
package sha3_vec_pkg;
  localparam int INSN_W = 32;
  localparam int REG_IDX_W = 5;
  localparam int AMT_W = 6;

  localparam logic [INSN_W-1:0] TRI_MASK  = 32'hff80_8000;
  localparam logic [INSN_W-1:0] TRI_MATCH = 32'hce00_0000;
  localparam logic [INSN_W-1:0] ROT_MASK  = 32'hffe0_0000;
  localparam logic [INSN_W-1:0] ROT_MATCH = 32'hce80_0000;

  typedef enum logic [2:0] {
    K_XOR3  = 3'd0,
    K_CLRX  = 3'd1,
    K_XROT  = 3'd2,
    K_UNDEF = 3'd3,
    K_NONE  = 3'd4
  } kind_t;

  typedef struct packed {
    kind_t                kind;
    logic [REG_IDX_W-1:0] dest;
    logic [AMT_W-1:0]     amt;
  } dec_t;
endpackage

// File: rtl/sha3_vec_decode.sv
module sha3_vec_decode
  import sha3_vec_pkg::*;
(
  input  logic              feat_en,
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);
  logic       is_tri;
  logic       is_rot;
  logic [1:0] sel;

  assign is_tri = (insn & TRI_MASK) == TRI_MATCH;
  assign is_rot = (insn & ROT_MASK) == ROT_MATCH;
  assign sel    = insn[22:21];

  always_comb begin
    dec.dest = insn[REG_IDX_W-1:0];
    dec.amt  = insn[15:10];
    if (!is_tri && !is_rot) begin
      dec.kind = K_NONE;
    end else if (!feat_en) begin
      dec.kind = K_UNDEF;
    end else if (is_rot) begin
      dec.kind = K_XROT;
    end else begin
      unique case (sel)
        2'd0:    dec.kind = K_XOR3;
        2'd1:    dec.kind = K_CLRX;
        default: dec.kind = K_UNDEF;
      endcase
    end
  end
endmodule

// File: rtl/sha3_lane_alu.sv
module sha3_lane_alu
  import sha3_vec_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  kind_t             kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic [LANE_W-1:0] src_n,
  input  logic [LANE_W-1:0] src_m,
  input  logic [LANE_W-1:0] src_a,
  output logic [LANE_W-1:0] y
);
  localparam int DBL_W = 2 * LANE_W;

  logic [LANE_W-1:0] mix;
  logic [DBL_W-1:0]  dbl;

  assign mix = src_n ^ src_m;
  assign dbl = {mix, mix} >> amt;

  always_comb begin
    unique case (kind)
      K_XOR3:  y = mix ^ src_a;
      K_CLRX:  y = src_n ^ (src_m & ~src_a);
      K_XROT:  y = dbl[LANE_W-1:0];
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/sha3_vec_unit.sv
module sha3_vec_unit
  import sha3_vec_pkg::*;
#(
  parameter int LANE_W = 64,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      feat_en,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [INSN_W-1:0]         in_insn,
  input  logic [LANES*LANE_W-1:0]   in_src_n,
  input  logic [LANES*LANE_W-1:0]   in_src_m,
  input  logic [LANES*LANE_W-1:0]   in_src_a,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANES*LANE_W-1:0]   out_result,
  output logic [REG_IDX_W-1:0]      out_dest,
  output logic                      out_wr,
  output logic                      out_undef,
  output logic                      out_unclaimed
);
  localparam int VEC_W = LANES * LANE_W;

  dec_t             dec;
  logic [VEC_W-1:0] alu_y;
  logic             exec;
  logic             take;

  sha3_vec_decode u_dec (
    .feat_en (feat_en),
    .insn    (in_insn),
    .dec     (dec)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sha3_lane_alu #(.LANE_W(LANE_W)) u_alu (
      .kind  (dec.kind),
      .amt   (dec.amt),
      .src_n (in_src_n[g*LANE_W +: LANE_W]),
      .src_m (in_src_m[g*LANE_W +: LANE_W]),
      .src_a (in_src_a[g*LANE_W +: LANE_W]),
      .y     (alu_y[g*LANE_W +: LANE_W])
    );
  end

  assign exec     = (dec.kind == K_XOR3) || (dec.kind == K_CLRX) || (dec.kind == K_XROT);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_result    <= '0;
      out_dest      <= '0;
      out_wr        <= 1'b0;
      out_undef     <= 1'b0;
      out_unclaimed <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result    <= exec ? alu_y : '0;
        out_dest      <= dec.dest;
        out_wr        <= exec;
        out_undef     <= dec.kind == K_UNDEF;
        out_unclaimed <= dec.kind == K_NONE;
      end
    end
  end

  // R10: stalled output holds
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_dest)
      && $stable(out_wr) && $stable(out_undef) && $stable(out_unclaimed));

  // R10: exactly one outcome flag per completed word
  p_one_flag_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({out_wr, out_undef, out_unclaimed}) == 1);

  // R5 / R6 / R7: no data when nothing is written
  p_zero_nowr_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_wr |-> out_result == '0);

  // R9: accepted word appears next cycle
  p_follow_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R6: disabled feature never writes
  p_nofeat_r6: assert property (@(posedge clk) disable iff (rst)
    take && !feat_en |=> !out_wr);

  // R11: empty after reset
  p_reset_r11: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/sha3_vec_unit_tb.sv
module sha3_vec_unit_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         feat_en;
  logic         in_valid;
  logic         in_ready;
  logic [31:0]  in_insn;
  logic [127:0] in_src_n, in_src_m, in_src_a;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_result;
  logic [4:0]   out_dest;
  logic         out_wr, out_undef, out_unclaimed;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sha3_vec_unit u_dut (
    .clk(clk), .rst(rst), .feat_en(feat_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_src_n(in_src_n), .in_src_m(in_src_m), .in_src_a(in_src_a),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_dest(out_dest), .out_wr(out_wr), .out_undef(out_undef), .out_unclaimed(out_unclaimed)
  );

  function automatic logic [31:0] enc_tri(logic [1:0] sel, logic [4:0] m, logic [4:0] a,
                                          logic [4:0] n, logic [4:0] d);
    return {9'b110011100, sel, m, 1'b0, a, n, d};
  endfunction

  function automatic logic [31:0] enc_rot(logic [4:0] m, logic [5:0] amt,
                                          logic [4:0] n, logic [4:0] d);
    return {11'b11001110100, m, amt, n, d};
  endfunction

  // op: 0 three-xor, 1 clear-xor, 2 xor-rotate
  function automatic logic [127:0] model(int op, int amt, logic [127:0] n,
                                         logic [127:0] m, logic [127:0] a);
    logic [127:0] r;
    for (int l = 0; l < 2; l++) begin
      logic [63:0] vn, vm, va, x;
      vn = n[l*64 +: 64]; vm = m[l*64 +: 64]; va = a[l*64 +: 64];
      case (op)
        0: x = vn ^ vm ^ va;
        1: x = vn ^ (vm & ~va);
        default: begin
          x = vn ^ vm;
          x = (x >> amt) | (x << (64 - amt));
        end
      endcase
      r[l*64 +: 64] = x;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] w, logic [127:0] n, logic [127:0] m, logic [127:0] a);
    @(negedge clk);
    in_insn = w; in_src_n = n; in_src_m = m; in_src_a = a;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic t_reset();
    chk("R11 out_valid", {127'd0, out_valid}, 128'd0);
    chk("R11 in_ready", {127'd0, in_ready}, 128'd1);
  endtask

  task automatic t_xor3();
    for (int i = 0; i < 4; i++) begin
      logic [127:0] n, m, a; logic [4:0] d;
      n = rnd128(); m = rnd128(); a = rnd128(); d = 5'($urandom);
      issue(enc_tri(2'd0, 5'd3, 5'd7, 5'd9, d), n, m, a);
      chk("R1 result", out_result, model(0, 0, n, m, a));
      chk("R9 valid/dest/wr", {121'd0, out_valid, out_wr, out_dest}, {121'd0, 1'b1, 1'b1, d});
    end
  endtask

  task automatic t_clrx();
    for (int i = 0; i < 4; i++) begin
      logic [127:0] n, m, a;
      n = rnd128(); m = rnd128(); a = rnd128();
      issue(enc_tri(2'd1, 5'd1, 5'd2, 5'd4, 5'd31), n, m, a);
      chk("R2 result", out_result, model(1, 0, n, m, a));
      chk("R2 wr", {127'd0, out_wr}, 128'd1);
    end
  endtask

  task automatic t_xrot();
    for (int i = 0; i < 6; i++) begin
      logic [127:0] n, m; int amt;
      n = rnd128(); m = rnd128(); amt = int'($urandom % 64);
      issue(enc_rot(5'd5, 6'(amt), 5'd6, 5'd8), n, m, rnd128());
      chk("R3 result", out_result, model(2, amt, n, m, 128'd0));
    end
  endtask

  task automatic t_rot_edges();
    logic [127:0] n, m;
    n = rnd128(); m = rnd128();
    issue(enc_rot(5'd0, 6'd0, 5'd0, 5'd1), n, m, 128'd0);
    chk("R4 amount 0", out_result, n ^ m);
    n = {64'h8000_0000_0000_0001, 64'h0000_0000_0000_0003};
    issue(enc_rot(5'd0, 6'd63, 5'd0, 5'd1), n, 128'd0, 128'd0);
    chk("R4 amount 63", out_result, {64'h0000_0000_0000_0003, 64'h0000_0000_0000_0006});
  endtask

  task automatic t_lanes();
    logic [127:0] n, m, a;
    n = {64'hffff_ffff_ffff_ffff, 64'h0};
    m = {64'h0, 64'h1234_5678_9abc_def0};
    a = {64'h0f0f_0f0f_0f0f_0f0f, 64'h0};
    issue(enc_tri(2'd1, 5'd0, 5'd0, 5'd0, 5'd0), n, m, a);
    chk("R8 lanes clear-xor", out_result,
        {64'hffff_ffff_ffff_ffff, 64'h1234_5678_9abc_def0});
    issue(enc_rot(5'd0, 6'd4, 5'd0, 5'd0), {64'h1, 64'h10}, 128'd0, 128'd0);
    chk("R8 lanes rotate", out_result, {64'h1000_0000_0000_0000, 64'h1});
  endtask

  task automatic t_unalloc();
    for (int s = 2; s < 4; s++) begin
      issue(enc_tri(2'(s), 5'd1, 5'd2, 5'd3, 5'd4), rnd128(), rnd128(), rnd128());
      chk("R5 result zero", out_result, 128'd0);
      chk("R5 flags undef/wr/uncl", {125'd0, out_undef, out_wr, out_unclaimed},
          {125'd0, 1'b1, 1'b0, 1'b0});
    end
  endtask

  task automatic t_nofeat();
    feat_en = 1'b0;
    issue(enc_tri(2'd0, 5'd1, 5'd2, 5'd3, 5'd4), rnd128(), rnd128(), rnd128());
    chk("R6 three-input class", {124'd0, out_undef, out_wr, out_unclaimed, |out_result},
        {124'd0, 1'b1, 1'b0, 1'b0, 1'b0});
    issue(enc_rot(5'd1, 6'd9, 5'd3, 5'd4), rnd128(), rnd128(), rnd128());
    chk("R6 rotate class", {124'd0, out_undef, out_wr, out_unclaimed, |out_result},
        {124'd0, 1'b1, 1'b0, 1'b0, 1'b0});
    feat_en = 1'b1;
  endtask

  task automatic t_unclaimed();
    // bit 15 set in the three-input pattern; and an unrelated word
    issue(enc_tri(2'd0, 5'd1, 5'd2, 5'd3, 5'd4) | 32'h0000_8000, rnd128(), rnd128(), rnd128());
    chk("R7 bit15 set", {124'd0, out_unclaimed, out_undef, out_wr, |out_result},
        {124'd0, 1'b1, 1'b0, 1'b0, 1'b0});
    issue(32'h1e20_1c00, rnd128(), rnd128(), rnd128());
    chk("R7 other word", {124'd0, out_unclaimed, out_undef, out_wr, |out_result},
        {124'd0, 1'b1, 1'b0, 1'b0, 1'b0});
  endtask

  task automatic t_stall();
    logic [127:0] n1, m1, a1, n2, m2, a2;
    n1 = rnd128(); m1 = rnd128(); a1 = rnd128();
    n2 = rnd128(); m2 = rnd128(); a2 = rnd128();
    @(negedge clk);
    out_ready = 1'b0;
    in_insn = enc_tri(2'd0, 5'd1, 5'd1, 5'd1, 5'd10);
    in_src_n = n1; in_src_m = m1; in_src_a = a1; in_valid = 1'b1;
    @(negedge clk);
    in_insn = enc_tri(2'd1, 5'd1, 5'd1, 5'd1, 5'd20);
    in_src_n = n2; in_src_m = m2; in_src_a = a2;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R10 in_ready low", {127'd0, in_ready}, 128'd0);
      chk("R10 result held", out_result, model(0, 0, n1, m1, a1));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 next word after stall", out_result, model(1, 0, n2, m2, a2));
    chk("R10 next dest", {123'd0, out_dest}, 128'd20);
    @(negedge clk);
    chk("R9 drains", {127'd0, out_valid}, 128'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; feat_en = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    in_insn = '0; in_src_n = '0; in_src_m = '0; in_src_a = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_xor3();
    t_clrx();
    t_xrot();
    t_rot_edges();
    t_lanes();
    t_unalloc();
    t_nofeat();
    t_unclaimed();
    t_stall();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule